// File: doc/BRIEF.md
# Configurable Branch Direction Predictor

This block answers one question for the fetch stage: will the conditional branch at a given PC be taken? The fetch stage presents a branch PC and its signed displacement on the query port. One clock later the block returns a registered taken or not-taken answer. Resolved outcomes come back from retirement on a separate training port. Only the training port ever changes the learned state.

A 2-bit mode register chooses how the answer is formed. In mode 0 every branch is predicted not-taken. In mode 1 a branch is predicted taken exactly when its displacement is negative, so backward branches are taken. Modes 2 and 3 use a table of 2-bit saturating counters. The table has 512 sets of 2 ways, and each way holds a valid bit, a tag and a counter. A 16-bit global outcome history is kept and brought out on a port, but it plays no part in indexing. A flush pulse discards everything the block has learned.

Top module: `bdir_predictor`

## Requirements
- R1: After reset the mode register holds 2, every table entry is invalid, `ghist` is 0 and `p_valid` is 0. A query in that state therefore predicts not-taken.
- R2: When the effective mode is 0, every query yields `p_taken` = 0.
- R3: When the effective mode is 1, `p_taken` equals the sign bit of `q_disp`. A negative displacement means taken. The table is not consulted.
- R4: In modes 2 and 3 a query that hits a valid way with a matching tag predicts the counter's bit 1. A query that misses predicts not-taken. Each answer appears on `p_taken`, with `p_valid` = 1, on the clock edge after the edge that samples `q_valid`.
- R5: The counter codes are 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken. A taken outcome adds one and stops at 11. A not-taken outcome subtracts one and stops at 00.
- R6: A training miss allocates a way whose counter starts at 01 and is then stepped by the outcome. After the first outcome the counter is therefore 10 for taken and 00 for not-taken.
- R7: The set is PC[10:2] XOR PC[19:11] and the tag is PC[31:11]. Two branches that map to the same set with different tags sit in the two ways at the same time.
- R8: On a training miss the invalid way is chosen first, with way 0 taking priority over way 1. When both ways are valid, the way that was not touched most recently by training is replaced.
- R9: Each training update shifts `ghist` left by one and places the outcome in bit 0.
- R10: A flush invalidates every entry, sets every counter to 01, clears `ghist` and clears the replacement bits. A flush takes priority over training in the same cycle.
- R11: A mode write (`cfg_wr`) applies to a query presented in the same cycle and to every later query.
- R12: When a query and a training update touch the same entry in one cycle, the query answers from the counter value before the update.
- R13: Queries never change any counter. Only the training port does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Mode write strobe |
| cfg_mode | input | 2 | New mode value: 0 never taken, 1 by displacement sign, 2 or 3 counter table |
| flush | input | 1 | Discard all learned state |
| q_valid | input | 1 | Query present |
| q_pc | input | PC_W | Query branch PC |
| q_disp | input | DISP_W | Query signed displacement |
| p_valid | output | 1 | Prediction valid, one cycle after the query |
| p_taken | output | 1 | Predicted direction |
| t_valid | input | 1 | Training update present |
| t_pc | input | PC_W | PC of the resolved branch |
| t_taken | input | 1 | Resolved outcome |
| ghist | output | HIST_W | Global outcome history |

## Verification
The bench drives each counter against both saturation limits. A counter that wrapped instead of stopping would turn a run of taken outcomes into a not-taken prediction. It fills one set with two tags and then adds a third. Wrong replacement state would evict the recently trained branch rather than the stale one. Other directed cases cover a mode write in the same cycle as a query, a query in the same cycle as training on the same entry, and repeated queries with no training. A design that delayed the mode write, forwarded the new counter value, or trained on queries would each return a wrong direction in one of these cases. Flushing after training must bring both the prediction and `ghist` back to their cold values.

// File: rtl/bdp_pkg.sv
// Shared types and helpers for the branch direction predictor.
// Assumes a 2-way organisation; the replacement state is one bit per set.
package bdp_pkg;

    typedef enum logic [1:0] {
        MODE_NEVER     = 2'd0,
        MODE_DISP      = 2'd1,
        MODE_TABLE     = 2'd2,
        MODE_TABLE_ALT = 2'd3
    } bdp_mode_e;

    typedef logic [1:0] ctr_t;

    localparam int   WAYS        = 2;
    localparam ctr_t CTR_WEAK_NT = 2'b01;

    // Saturating step of a 2-bit direction counter
    function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
        if (taken) return (c == 2'b11) ? c : c + 2'b01;
        else       return (c == 2'b00) ? c : c - 2'b01;
    endfunction

endpackage

// File: rtl/bdp_index.sv
// Turns a branch PC into a set index and a tag.
// Index = PC[IDX_W+1:2] XOR PC[2*IDX_W+1:IDX_W+2]; tag = all PC bits above the low index field.
// Assumes PC_W >= 2*IDX_W + 2 and word-aligned branches (PC[1:0] ignored).
module bdp_index #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 9,
    localparam int TAG_W = PC_W - IDX_W - 2
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);
    logic pc_lsb_unused;

    assign idx           = pc[IDX_W+1:2] ^ pc[2*IDX_W+1:IDX_W+2];
    assign tag           = pc[PC_W-1:IDX_W+2];
    assign pc_lsb_unused = ^pc[1:0];

endmodule

// File: rtl/bdp_history.sv
// Global outcome history: shifts in each resolved outcome at bit 0.
// Assumes upd is only asserted for retired conditional branches; flush clears it.
module bdp_history #(
    parameter int HIST_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              upd,
    input  logic              taken,
    output logic [HIST_W-1:0] hist
);
    // history shift register with clear on reset or flush
    always_ff @(posedge clk) begin
        if (!rst_n || flush) hist <= '0;
        else if (upd)        hist <= {hist[HIST_W-2:0], taken};
    end

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !flush) |=> hist == {$past(hist[HIST_W-2:0]), $past(taken)}); // R9
    AST_HIST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> hist == '0); // R10

endmodule

// File: rtl/bdp_table.sv
// Set-associative table of 2-bit direction counters with tag and valid per way.
// Query side is a pure read of current state; training hits step the counter,
// misses allocate (invalid way first, else the LRU way) starting from weak not-taken.
// Flush has priority over training. Assumes WAYS == 2 (one LRU bit per set).
module bdp_table
    import bdp_pkg::*;
#(
    parameter int IDX_W = 9,
    parameter int TAG_W = 21,
    localparam int SETS = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [IDX_W-1:0] q_idx,
    input  logic [TAG_W-1:0] q_tag,
    output logic             q_hit,
    output ctr_t             q_ctr,
    input  logic             t_valid,
    input  logic [IDX_W-1:0] t_idx,
    input  logic [TAG_W-1:0] t_tag,
    input  logic             t_taken
);
    logic             valid_q [SETS][WAYS];
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    ctr_t             ctr_q   [SETS][WAYS];
    logic             lru_q   [SETS];

    logic [WAYS-1:0]  q_hit_w;
    logic [WAYS-1:0]  t_hit_w;
    logic             t_way;
    ctr_t             t_base;

    // per-way tag compare for both ports
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign q_hit_w[w] = valid_q[q_idx][w] && (tag_q[q_idx][w] == q_tag);
        assign t_hit_w[w] = valid_q[t_idx][w] && (tag_q[t_idx][w] == t_tag);
    end

    // query read: counter of the hitting way
    always_comb begin
        q_hit = |q_hit_w;
        q_ctr = q_hit_w[1] ? ctr_q[q_idx][1] : ctr_q[q_idx][0];
    end

    // training way choice: hit way, else invalid way, else LRU way
    always_comb begin
        if (t_hit_w[0])               t_way = 1'b0;
        else if (t_hit_w[1])          t_way = 1'b1;
        else if (!valid_q[t_idx][0])  t_way = 1'b0;
        else if (!valid_q[t_idx][1])  t_way = 1'b1;
        else                          t_way = lru_q[t_idx];
        t_base = (|t_hit_w) ? ctr_q[t_idx][t_way] : CTR_WEAK_NT;
    end

    // valid, counter and LRU state: cleared by reset or flush, stepped by training
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int s = 0; s < SETS; s++) begin
                lru_q[s] <= 1'b0;
                for (int w = 0; w < WAYS; w++) begin
                    valid_q[s][w] <= 1'b0;
                    ctr_q[s][w]   <= CTR_WEAK_NT;
                end
            end
        end else if (t_valid) begin
            valid_q[t_idx][t_way] <= 1'b1;
            ctr_q[t_idx][t_way]   <= ctr_step(t_base, t_taken);
            lru_q[t_idx]          <= ~t_way;
        end
    end

    // tag write on allocation or refresh (no reset needed, guarded by valid)
    always_ff @(posedge clk) begin
        if (rst_n && !flush && t_valid) tag_q[t_idx][t_way] <= t_tag;
    end

    AST_ONE_WAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q_hit_w)); // R7
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !q_hit); // R10
    AST_CTR_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (t_valid && !flush && (|t_hit_w) && t_taken && t_base == 2'b11)
        |=> ctr_q[$past(t_idx)][$past(t_way)] == 2'b11); // R5
    AST_CTR_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (t_valid && !flush && (|t_hit_w) && !t_taken && t_base == 2'b00)
        |=> ctr_q[$past(t_idx)][$past(t_way)] == 2'b00); // R5

endmodule

// File: rtl/bdir_predictor.sv
// Branch direction predictor top. Holds the mode register (reset value 2),
// selects the strategy per query and registers the answer for one cycle.
// A mode write bypasses to a query in the same cycle. Queries read state only;
// training and flush are the sole writers of learned state.
module bdir_predictor
    import bdp_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int DISP_W = 21,
    parameter int IDX_W  = 9,
    parameter int HIST_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_mode,
    input  logic              flush,
    input  logic              q_valid,
    input  logic [PC_W-1:0]   q_pc,
    input  logic [DISP_W-1:0] q_disp,
    output logic              p_valid,
    output logic              p_taken,
    input  logic              t_valid,
    input  logic [PC_W-1:0]   t_pc,
    input  logic              t_taken,
    output logic [HIST_W-1:0] ghist
);
    localparam int TAG_W = PC_W - IDX_W - 2;

    bdp_mode_e        mode_q;
    bdp_mode_e        eff_mode;
    logic [IDX_W-1:0] q_idx, t_idx;
    logic [TAG_W-1:0] q_tag, t_tag;
    logic             tbl_hit;
    ctr_t             tbl_ctr;
    logic             pred_next;
    logic             disp_low_unused;

    assign disp_low_unused = ^q_disp[DISP_W-2:0];

    bdp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_qidx (.pc(q_pc), .idx(q_idx), .tag(q_tag));
    bdp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_tidx (.pc(t_pc), .idx(t_idx), .tag(t_tag));

    bdp_table #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_table (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .q_idx(q_idx), .q_tag(q_tag), .q_hit(tbl_hit), .q_ctr(tbl_ctr),
        .t_valid(t_valid), .t_idx(t_idx), .t_tag(t_tag), .t_taken(t_taken)
    );

    bdp_history #(.HIST_W(HIST_W)) u_hist (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .upd(t_valid), .taken(t_taken), .hist(ghist)
    );

    // mode register, default is the counter table
    always_ff @(posedge clk) begin
        if (!rst_n)      mode_q <= MODE_TABLE;
        else if (cfg_wr) mode_q <= bdp_mode_e'(cfg_mode);
    end

    // strategy select with same-cycle bypass of a mode write
    always_comb begin
        eff_mode = cfg_wr ? bdp_mode_e'(cfg_mode) : mode_q;
        case (eff_mode)
            MODE_NEVER: pred_next = 1'b0;
            MODE_DISP:  pred_next = q_disp[DISP_W-1];
            default:    pred_next = tbl_hit & tbl_ctr[1];
        endcase
    end

    // registered answer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_valid <= 1'b0;
            p_taken <= 1'b0;
        end else begin
            p_valid <= q_valid;
            p_taken <= q_valid & pred_next;
        end
    end

    AST_MODE_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && eff_mode == MODE_NEVER) |=> (p_valid && !p_taken)); // R2
    AST_MODE_DISP: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && eff_mode == MODE_DISP) |=> (p_taken == $past(q_disp[DISP_W-1]))); // R3
    AST_TABLE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && eff_mode[1] && !tbl_hit) |=> !p_taken); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |=> (!p_valid && !p_taken)); // R4

endmodule

// File: tb/bdir_predictor_bench.sv
module bdir_predictor_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic [1:0]  cfg_mode;
    logic        flush;
    logic        q_valid;
    logic [31:0] q_pc;
    logic [20:0] q_disp;
    logic        p_valid;
    logic        p_taken;
    logic        t_valid;
    logic [31:0] t_pc;
    logic        t_taken;
    logic [15:0] ghist;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [31:0] PA = 32'h0000_1000; // set 2
    localparam logic [31:0] PB = 32'h0010_0008; // set 2, other tag
    localparam logic [31:0] PC = 32'h0020_0008; // set 2, third tag
    localparam logic [31:0] PD = 32'h0000_4444;
    localparam logic [31:0] PE = 32'h0000_8888;
    localparam logic [20:0] NEG4 = 21'h1FFFFC;
    localparam logic [20:0] POS8 = 21'h000008;

    always #5 clk = ~clk;

    bdir_predictor u_bdir_predictor (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .flush(flush),
        .q_valid(q_valid), .q_pc(q_pc), .q_disp(q_disp),
        .p_valid(p_valid), .p_taken(p_taken),
        .t_valid(t_valid), .t_pc(t_pc), .t_taken(t_taken), .ghist(ghist)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic train(input logic [31:0] pc, input logic tk);
        @(negedge clk);
        t_valid = 1'b1; t_pc = pc; t_taken = tk;
        @(negedge clk);
        t_valid = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk); cfg_wr = 1'b1; cfg_mode = m;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    // query, optionally with a same-cycle mode write and/or training update
    task automatic query_full(input logic [31:0] pc, input logic [20:0] disp,
                              input logic wr, input logic [1:0] m,
                              input logic tr, input logic tk,
                              input string req, input logic exp);
        @(negedge clk);
        q_valid = 1'b1; q_pc = pc; q_disp = disp;
        cfg_wr = wr; cfg_mode = m;
        t_valid = tr; t_pc = pc; t_taken = tk;
        @(posedge clk); #1;
        check(req, {31'd0, p_valid}, 32'd1);
        check(req, {31'd0, p_taken}, {31'd0, exp});
        @(negedge clk);
        q_valid = 1'b0; cfg_wr = 1'b0; t_valid = 1'b0;
    endtask

    task automatic query(input logic [31:0] pc, input logic [20:0] disp,
                         input string req, input logic exp);
        query_full(pc, disp, 1'b0, 2'd0, 1'b0, 1'b0, req, exp);
    endtask

    task automatic t_reset();
        check("R1 p_valid", {31'd0, p_valid}, 32'd0);
        check("R1 ghist", {16'd0, ghist}, 32'd0);
        query(PA, POS8, "R1 cold query", 1'b0);
    endtask

    task automatic t_modes();
        do_flush();
        train(PA, 1'b1);
        query(PA, POS8, "R6 first taken", 1'b1);
        set_mode(2'd0);
        query(PA, NEG4, "R2 never", 1'b0);
        set_mode(2'd1);
        query(PA, NEG4, "R3 backward", 1'b1);
        query(PA, POS8, "R3 forward", 1'b0);
        query(PD, NEG4, "R3 no table", 1'b1);
        set_mode(2'd3);
        query(PA, POS8, "R4 mode3 hit", 1'b1);
        query(PD, NEG4, "R4 miss", 1'b0);
        set_mode(2'd2);
    endtask

    task automatic t_sat();
        do_flush();
        train(PA, 1'b1); train(PA, 1'b1); train(PA, 1'b1);
        train(PA, 1'b0);
        query(PA, POS8, "R5 sat high", 1'b1);
        train(PA, 1'b0);
        query(PA, POS8, "R5 weak nt", 1'b0);
        train(PA, 1'b0); train(PA, 1'b0); train(PA, 1'b0);
        train(PA, 1'b1); train(PA, 1'b1);
        query(PA, POS8, "R5 sat low", 1'b1);
    endtask

    task automatic t_alloc();
        do_flush();
        train(PD, 1'b0);
        train(PD, 1'b1);
        query(PD, POS8, "R6 alloc nt", 1'b0);
    endtask

    task automatic t_ways();
        do_flush();
        train(PA, 1'b1); train(PA, 1'b1);
        train(PB, 1'b1);
        query(PA, POS8, "R7 way A", 1'b1);
        query(PB, POS8, "R7 way B", 1'b1);
        train(PA, 1'b1);
        train(PC, 1'b1);
        query(PB, POS8, "R8 evicted", 1'b0);
        query(PA, POS8, "R8 kept", 1'b1);
        query(PC, POS8, "R8 new", 1'b1);
    endtask

    task automatic t_hist();
        do_flush();
        check("R9 clear", {16'd0, ghist}, 32'd0);
        train(PE, 1'b1); train(PE, 1'b0); train(PE, 1'b1);
        #1 check("R9 pattern", {16'd0, ghist}, 32'h0005);
        for (int i = 0; i < 14; i++) train(PE, 1'b1);
        #1 check("R9 shift out", {16'd0, ghist}, 32'h7FFF);
    endtask

    task automatic t_flush();
        train(PA, 1'b1); train(PA, 1'b1);
        do_flush();
        #1 check("R10 ghist", {16'd0, ghist}, 32'd0);
        query(PA, POS8, "R10 cold", 1'b0);
        train(PA, 1'b1);
        query(PA, POS8, "R10 relearn", 1'b1);
    endtask

    task automatic t_noquerytrain();
        do_flush();
        train(PA, 1'b1); train(PA, 1'b0);
        for (int i = 0; i < 4; i++) query(PA, NEG4, "R13 repeat", 1'b0);
        train(PA, 1'b1);
        query(PA, POS8, "R13 step up", 1'b1);
        train(PA, 1'b0);
        query(PA, POS8, "R13 step down", 1'b0);
    endtask

    task automatic t_bypass();
        do_flush();
        train(PA, 1'b1);
        query_full(PA, POS8, 1'b1, 2'd0, 1'b0, 1'b0, "R11 same cycle", 1'b0);
        query(PA, POS8, "R11 held", 1'b0);
        query_full(PA, POS8, 1'b1, 2'd2, 1'b0, 1'b0, "R11 back", 1'b1);
    endtask

    task automatic t_same();
        do_flush();
        train(PA, 1'b1);
        query_full(PA, POS8, 1'b0, 2'd0, 1'b1, 1'b0, "R12 pre-update", 1'b1);
        query(PA, POS8, "R12 after", 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_mode = 2'd0; flush = 1'b0;
        q_valid = 1'b0; q_pc = '0; q_disp = '0;
        t_valid = 1'b0; t_pc = '0; t_taken = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_modes();
        t_sat();
        t_alloc();
        t_ways();
        t_hist();
        t_flush();
        t_noquerytrain();
        t_bypass();
        t_same();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule